// File: doc/BRIEF.md
# Sequential Memory Sweep Controller

This block is a control state machine that visits every location of an external memory exactly once, in ascending address order. It drives chip select and a read or write strobe for each location. It steers an address counter through two lines: an active-low synchronous clear and a one-cycle increment pulse. The counter is modelled behaviourally inside the block, and its value is presented as the memory address.

A sweep begins with a `start` pulse while the controller is idle. The controller first clears the counter. Each location then takes the same fixed four-step access. The address moves on only after the memory has been deselected, so the address never changes while chip select is active. A data strobe that marks the strobe cycle is passed out so that outside logic can drive or capture data. The `wr_mode` input picks a write sweep or a read sweep and is sampled when the sweep starts.

States and transitions:
- IDLE goes to CLEAR on `start`.
- CLEAR goes to SELECT.
- SELECT goes to STROBE.
- STROBE goes to DESELECT.
- DESELECT goes to INCR, or goes to DONE when the address is at its last value.
- INCR goes to SELECT.
- DONE goes to IDLE.

Top module: `mem_sweep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows the idle outputs. Those outputs are `cs`, `we`, `rd`, `data_stb`, `inc`, `busy` and `done` low, `clr_n` high, and `addr` zero.
- R2: When `start` is high in an idle cycle, the next cycle is a single clear cycle with `clr_n` low and `busy` high. `addr` reads zero from the cycle after it.
- R3: Each location takes a fixed access sequence, one clock per step. The select step has only `cs` high (among cs/we/rd/data_stb/inc). The strobe step has `cs`, one strobe and `data_stb` high. The deselect step has all of them low. The increment step has only `inc` high.
- R4: `addr` holds the same value in every cycle in which `cs` is high.
- R5: `inc` is high for exactly one cycle, only after a cycle with `cs` low. `addr` is one greater in the following cycle.
- R6: Strobe cycles present the addresses 0, 1, 2 … 2^ADDR_W−1 in that order, each exactly once per sweep.
- R7: After the deselect step at the all-ones address, no increment follows. `done` is high for one cycle with `busy` low, and the controller then returns to idle with `addr` still all ones.
- R8: `busy` is high from the clear cycle through the last deselect cycle, which is 4·2^ADDR_W cycles per sweep, and low otherwise.
- R9: `start` has no effect while `busy` or `done` is high; the running sweep's length and sequence are unchanged.
- R10: `wr_mode`=1 gives a write sweep (`we` high in strobe steps), and `wr_mode`=0 gives a read sweep (`rd` high). The value is taken in the cycle `start` is accepted, and changes during a sweep are ignored.
- R11: A reset during a sweep returns the controller to idle in the next cycle with `addr` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sweep (taken only when idle) |
| wr_mode | input | 1 | 1 = write sweep, 0 = read sweep |
| cs | output | 1 | Memory chip select, active high |
| we | output | 1 | Write strobe |
| rd | output | 1 | Read strobe |
| data_stb | output | 1 | Data strobe for external pattern logic |
| clr_n | output | 1 | Address counter clear, active low |
| inc | output | 1 | Address counter increment pulse |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| addr | output | ADDR_W | Current memory address |

## Verification
The controller is exercised with a write sweep and with a read sweep during which `wr_mode` toggles on every cycle. Together these separate a strobe choice that is sampled once at start from one that follows the live input. A sweep in which `start` stays high throughout shows that start is ignored while busy and in the done cycle. It also shows that a new sweep begins back-to-back once the controller is idle again. A reset partway through a sweep, followed by a fresh sweep, confirms that the address is cleared and that the full ordering restarts from location zero.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CLEAR  = 3'd1,
        S_SELECT = 3'd2,
        S_STROBE = 3'd3,
        S_DESEL  = 3'd4,
        S_INCR   = 3'd5,
        S_DONE   = 3'd6
    } sweep_state_t;

    typedef struct packed {
        logic cs;
        logic we;
        logic rd;
        logic stb;
        logic clr_n;
        logic inc;
        logic busy;
        logic done;
    } sweep_ctl_t;

endpackage

// File: rtl/msc_addr_counter.sv
module msc_addr_counter #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              inc,
    output logic [ADDR_W-1:0] count,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!clr_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == LAST);
endmodule

// File: rtl/msc_seq_fsm.sv
module msc_seq_fsm
    import msc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       wr_mode,
    input  logic       at_last,
    output sweep_ctl_t ctl
);
    sweep_state_t state, state_nx;
    logic         mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            mode_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                mode_q <= wr_mode;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   state_nx = start ? S_CLEAR : S_IDLE;
            S_CLEAR:  state_nx = S_SELECT;
            S_SELECT: state_nx = S_STROBE;
            S_STROBE: state_nx = S_DESEL;
            S_DESEL:  state_nx = at_last ? S_DONE : S_INCR;
            S_INCR:   state_nx = S_SELECT;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl       = '0;
        ctl.clr_n = 1'b1;
        unique case (state)
            S_IDLE: ;
            S_CLEAR: begin
                ctl.clr_n = 1'b0;
                ctl.busy  = 1'b1;
            end
            S_SELECT: begin
                ctl.cs   = 1'b1;
                ctl.busy = 1'b1;
            end
            S_STROBE: begin
                ctl.cs   = 1'b1;
                ctl.we   = mode_q;
                ctl.rd   = !mode_q;
                ctl.stb  = 1'b1;
                ctl.busy = 1'b1;
            end
            S_DESEL: ctl.busy = 1'b1;
            S_INCR: begin
                ctl.inc  = 1'b1;
                ctl.busy = 1'b1;
            end
            S_DONE:  ctl.done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mem_sweep_ctrl.sv
module mem_sweep_ctrl
    import msc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_mode,
    output logic              cs,
    output logic              we,
    output logic              rd,
    output logic              data_stb,
    output logic              clr_n,
    output logic              inc,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] addr
);
    sweep_ctl_t ctl;
    logic       at_last;

    msc_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .wr_mode (wr_mode),
        .at_last (at_last),
        .ctl     (ctl)
    );

    msc_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (ctl.clr_n),
        .inc     (ctl.inc),
        .count   (addr),
        .at_last (at_last)
    );

    assign cs       = ctl.cs;
    assign we       = ctl.we;
    assign rd       = ctl.rd;
    assign data_stb = ctl.stb;
    assign clr_n    = ctl.clr_n;
    assign inc      = ctl.inc;
    assign busy     = ctl.busy;
    assign done     = ctl.done;
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              we,
    input logic              rd,
    input logic              data_stb,
    input logic              clr_n,
    input logic              inc,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] addr
);
    AST_ADDR_STABLE_CS: assert property (@(posedge clk) disable iff (rst)
        (cs && $past(cs)) |-> (addr == $past(addr))); // R4

    AST_INC_AFTER_DESEL: assert property (@(posedge clk) disable iff (rst)
        inc |-> (!cs && !$past(cs))); // R5

    AST_INC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        inc |=> !inc); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        $past(inc) |-> (addr == ADDR_W'($past(addr) + 1'b1))); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (addr == '0)); // R2

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (we || rd || data_stb) |-> cs); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({we, rd}) <= 1); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && &addr)); // R7
endmodule

bind mem_sweep_ctrl msc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .we       (we),
    .rd       (rd),
    .data_stb (data_stb),
    .clr_n    (clr_n),
    .inc      (inc),
    .busy     (busy),
    .done     (done),
    .addr     (addr)
);

// File: tb/tb_mem_sweep_ctrl.sv
module tb_mem_sweep_ctrl;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst, start, wr_mode;
    logic cs, we, rd, data_stb, clr_n, inc, busy, done;
    logic [AW-1:0] addr;

    always #10 clk = ~clk;

    mem_sweep_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .wr_mode(wr_mode),
        .cs(cs), .we(we), .rd(rd), .data_stb(data_stb), .clr_n(clr_n),
        .inc(inc), .busy(busy), .done(done), .addr(addr)
    );

    // expected entry: flags {cs,we,rd,stb,clr_n,inc,busy,done}, address, tag
    typedef struct {
        logic [7:0]    fl;
        logic [AW-1:0] ad;
        int            tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   addr_m = 0;
    bit   cur_idle = 1'b0;
    int   idle_tag = 1;
    int   stb_next = 0;
    int   busy_cnt = 0;
    bit   r9_test  = 1'b0;
    bit   r10_test = 1'b0;
    int   cyc      = 0;

    function automatic string rtag(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            5: return "R5";   6: return "R6";   7: return "R7";
            8: return "R8";   9: return "R9";   10: return "R10";
            11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(bit ok, int t, string what, int act, int ex);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rtag(t), what, act, ex);
        end
    endtask

    task automatic push(logic [7:0] fl, int a, int t);
        exp_t e;
        e.fl = fl; e.ad = AW'(a); e.tag = t;
        q.push_back(e);
    endtask

    task automatic push_sweep(bit m);
        push(8'b0000_0010, addr_m, 2);                // clear
        for (int a = 0; a < N; a++) begin
            push(8'b1000_1010, a, 3);                 // select
            push({1'b1, m, !m, 1'b1, 4'b1010}, a, 10); // strobe
            push(8'b0000_1010, a, 3);                 // deselect
            if (a < N - 1) push(8'b0000_1110, a, 5);  // increment
        end
        push(8'b0000_1001, N - 1, 7);                 // done
        addr_m = N - 1;
    endtask

    // drive inputs for the coming edge, then compare at the next negedge
    task automatic step(bit st, bit wm, bit rs);
        exp_t e;
        logic [7:0] act;
        start = st; wr_mode = wm; rst = rs;
        if (rs) begin
            q.delete();
            addr_m = 0;
        end else if (st && cur_idle && q.size() == 0) begin
            push_sweep(wm);
        end
        @(negedge clk);
        cyc++;
        if (q.size() != 0) begin
            e = q.pop_front();
            cur_idle = 1'b0;
        end else begin
            e.fl = 8'b0000_1000; e.ad = AW'(addr_m); e.tag = idle_tag;
            cur_idle = 1'b1;
        end
        act = {cs, we, rd, data_stb, clr_n, inc, busy, done};
        chk(act == e.fl && addr == e.ad, e.tag, "outputs{flags,addr}",
            {act, 8'(addr)}, {e.fl, 8'(e.ad)});
        idle_tag = 1;
        // ordering of strobed addresses
        if (!clr_n) stb_next = 0;
        if (data_stb) begin
            chk(int'(addr) == stb_next, 6, "strobe address order", addr, stb_next);
            stb_next++;
        end
        if (busy) busy_cnt++;
        if (done) begin
            chk(busy_cnt == 4 * N, 8, "busy cycles per sweep", busy_cnt, 4 * N);
            if (r9_test) chk(busy_cnt == 4 * N, 9, "sweep length with start held", busy_cnt, 4 * N);
            if (r10_test) chk(stb_next == N, 10, "strobes in mode-toggled sweep", stb_next, N);
            busy_cnt = 0;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset
        for (int i = 0; i < 3; i++) step(0, 1, 1);
        for (int i = 0; i < 3; i++) step(0, 1, 0);
        // write sweep (R2, R3, R5, R6, R7, R8)
        step(1, 1, 0);
        for (int i = 0; i < 4 * N + 3; i++) step(0, 1, 0);
        // read sweep with wr_mode toggling (R10)
        r10_test = 1'b1;
        step(1, 0, 0);
        for (int i = 0; i < 4 * N + 3; i++) step(0, i[0], 0);
        r10_test = 1'b0;
        // start held high throughout: ignored while busy/done (R9)
        r9_test = 1'b1;
        for (int i = 0; i < 8 * N + 4; i++) step(1, 1, 0);
        step(0, 1, 0);
        while (!cur_idle) step(0, 1, 0);
        r9_test = 1'b0;
        // reset in mid sweep (R11)
        step(1, 0, 0);
        for (int i = 0; i < 2 * N + 1; i++) step(0, 0, 0);
        busy_cnt = 0;
        step(0, 0, 1);
        idle_tag = 11;
        busy_cnt = 0;
        step(0, 0, 0);
        busy_cnt = 0;
        step(0, 0, 0);
        step(1, 1, 0);
        for (int i = 0; i < 4 * N + 3; i++) step(0, 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule